// File: doc/BRIEF.md
# PCI Power-State Tracker

This block follows the power-management state of a PCI network function: fully unpowered (G3), powered but not yet configured (D0 uninitialized), running (D0 active), software-requested sleep (D3 hot) and main-supply-off sleep held up by the auxiliary rail (D3 cold). It samples the bus reset, the two-bit power-state field that software writes, the auxiliary-supply detect, the main-supply power-good, the wake enable and a vector of wake events. Every input is sampled on the block clock.

From these it drives a one-hot state vector, a request to stop the PLL and derived clocks, a flag that isolates the function from the bus, a flag that blocks Ethernet traffic, and an active-low wake output. It also drives three reset-scope requests: a full power-on reset, a reset that spares the wake context, and a PHY reset into all-capable auto-negotiation. Each reset request is a pulse of `PULSE_LEN` cycles. The wake output latches and stays low until software clears it. It is also cleared when all power is lost.

Top module: `pci_pm_tracker`

## Requirements
- R1: `pm_state` is one-hot, with bit 0 = G3, bit 1 = D0 uninitialized, bit 2 = D0 active, bit 3 = D3 hot and bit 4 = D3 cold. After `arst_n` it reads G3, with `pme_n` high and every request output low.
- R2: When `pwr_good` and `aux_det` are both low, the state is G3 after the next clock edge, whatever the current state.
- R3: In G3, a high `pwr_good` moves to D0 uninitialized. Otherwise, a high `aux_det` moves to D3 cold. Leaving G3 holds `rst_por` high for exactly `PULSE_LEN` cycles, starting with the cycle of the new state. Entering D0 uninitialized from G3 also pulses `phy_rst_req`.
- R4: D0 uninitialized moves to D0 active when `sw_enable` is high and `pci_rst_n` is high. It stays put while `pci_rst_n` is low.
- R5: In D0 active, a low `pci_rst_n` returns the state to D0 uninitialized. Otherwise, `pm_field` = 2'b11 moves it to D3 hot. The reset has priority.
- R6: D3 hot moves to D0 uninitialized only when `pci_rst_n` is high in one cycle and low in the next, with `pm_field` = 2'b11 and `pwr_good` high. This pulses `rst_keep_pme` but not `phy_rst_req`. A `pci_rst_n` that is merely held low leaves the state in D3 hot.
- R7: From D0 uninitialized, D0 active or D3 hot, a low `pwr_good` with `aux_det` high moves to D3 cold.
- R8: In D3 cold, `pci_rst_n` and `pm_field` have no effect on the state. `clk_gate_req`, `bus_isolate` and `mac_block` are high exactly while the state is D3 cold.
- R9: D3 cold moves to D0 uninitialized when `pwr_good` is high. This pulses `rst_keep_pme` and `phy_rst_req` for `PULSE_LEN` cycles and leaves `rst_por` low.
- R10: `pme_n` goes low in the cycle after any bit of `wake_evt` is high while all three of these hold: the state is D3 cold, `pme_en` is high and `aux_det` is high. The bits of `wake_evt` are bit 0 = magic packet, bit 1 = wake frame and bit 2 = link change. A wake event in any other state, or with `pme_en` low, leaves `pme_n` high.
- R11: Once low, `pme_n` stays low, including across the D3 cold to D0 uninitialized move, until `pme_clr` is high. A new wake event in the same cycle as `pme_clr` wins. `pme_n` returns high when the state becomes G3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| arst_n | input | 1 | Asynchronous active-low register reset |
| pci_rst_n | input | 1 | Bus reset, active low |
| pm_field | input | 2 | Power-state field written by software |
| aux_det | input | 1 | Auxiliary supply present |
| pwr_good | input | 1 | Main supply good |
| pme_en | input | 1 | Wake output enable |
| wake_evt | input | WAKE_W | Wake events (0 magic, 1 frame, 2 link change) |
| sw_enable | input | 1 | Software marks the function configured |
| pme_clr | input | 1 | Write-one-to-clear pulse for the wake status |
| pm_state | output | 5 | One-hot current state |
| clk_gate_req | output | 1 | Request to stop the PLL and derived clocks |
| bus_isolate | output | 1 | Ignore bus accesses |
| mac_block | output | 1 | Block Ethernet transmit and receive |
| pme_n | output | 1 | Active-low wake output |
| rst_por | output | 1 | Full power-on reset request |
| rst_keep_pme | output | 1 | Reset request that spares the wake context |
| phy_rst_req | output | 1 | PHY reset into all-capable auto-negotiation |

## Verification
A wrong internal state appears on `pm_state` one edge after the input that caused it, so the vector walk checks the state after every single edge. The clock-gate, isolate and traffic-block flags are decoded from the state without delay, so a stray D3 cold is visible on them in the same cycle. A wrongly chosen reset scope shows on the three pulse outputs in the first cycle of D0 uninitialized. A pulse of the wrong length shows `PULSE_LEN` cycles later. A wake latch that drops too early, or sets when it should not, shows on `pme_n` one cycle after the offending input.

// File: rtl/pm_track_pkg.sv
package pm_track_pkg;
   localparam int ST_N = 5;

   typedef enum logic [ST_N-1:0] {
      PS_G3  = 5'b00001,
      PS_D0U = 5'b00010,
      PS_D0A = 5'b00100,
      PS_D3H = 5'b01000,
      PS_D3C = 5'b10000
   } pm_state_e;

   localparam logic [1:0] FIELD_SLEEP = 2'b11;

   // indices into the reset-request vector
   localparam int RQ_POR  = 0;
   localparam int RQ_KEEP = 1;
   localparam int RQ_PHY  = 2;
   localparam int RQ_N    = 3;
endpackage

// File: rtl/pm_state_fsm.sv
module pm_state_fsm
   import pm_track_pkg::*;
(
   input  logic      clk,
   input  logic      arst_n,
   input  logic      pci_rst_n,
   input  logic [1:0] pm_field,
   input  logic      aux_det,
   input  logic      pwr_good,
   input  logic      sw_enable,
   output pm_state_e state_q,
   output logic      ev_por,
   output logic      ev_keep,
   output logic      ev_phy
);
   pm_state_e state_d;
   logic      rst_seen_q;
   logic      rst_fall;
   logic      all_off;

   assign rst_fall = rst_seen_q && !pci_rst_n;
   assign all_off  = !pwr_good && !aux_det;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q    <= PS_G3;
         rst_seen_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         rst_seen_q <= pci_rst_n;
      end
   end

   always_comb begin
      state_d = state_q;
      if (all_off) begin
         state_d = PS_G3;
      end else begin
         unique case (state_q)
            PS_G3: begin
               if (pwr_good)     state_d = PS_D0U;
               else if (aux_det) state_d = PS_D3C;
            end
            PS_D0U: begin
               if (!pwr_good)                  state_d = PS_D3C;
               else if (pci_rst_n && sw_enable) state_d = PS_D0A;
            end
            PS_D0A: begin
               if (!pwr_good)                    state_d = PS_D3C;
               else if (!pci_rst_n)              state_d = PS_D0U;
               else if (pm_field == FIELD_SLEEP) state_d = PS_D3H;
            end
            PS_D3H: begin
               if (!pwr_good)                                 state_d = PS_D3C;
               else if (rst_fall && pm_field == FIELD_SLEEP)  state_d = PS_D0U;
            end
            PS_D3C: begin
               if (pwr_good) state_d = PS_D0U;
            end
            default: state_d = PS_G3;
         endcase
      end
   end

   // reset-scope events, decided from the transition being taken
   always_comb begin
      ev_por  = (state_q == PS_G3) && (state_d != PS_G3);
      ev_keep = (state_d == PS_D0U) &&
                (state_q == PS_D0A || state_q == PS_D3H || state_q == PS_D3C);
      ev_phy  = (state_d == PS_D0U) && (state_q == PS_G3 || state_q == PS_D3C);
   end

   a_r1_onehot: assert property (@(posedge clk) disable iff (!arst_n)
      $countones(state_q) == 1);

   a_r2_power_loss: assert property (@(posedge clk) disable iff (!arst_n)
      (!pwr_good && !aux_det) |=> state_q == PS_G3);

   a_r8_d3c_ignores_bus: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PS_D3C && aux_det && !pwr_good) |=> state_q == PS_D3C);

   a_r6_hold_without_fall: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PS_D3H && pwr_good && pci_rst_n == rst_seen_q) |=> state_q == PS_D3H);

   a_r5_reset_priority: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PS_D0A && pwr_good && !pci_rst_n) |=> state_q == PS_D0U);
endmodule

// File: rtl/pm_pulse_stretch.sv
module pm_pulse_stretch #(
   parameter int LEN = 2
) (
   input  logic clk,
   input  logic arst_n,
   input  logic trig,
   output logic pulse
);
   localparam int CW = $clog2(LEN + 1);

   if (LEN < 1) begin : g_bad_len
      $error("pm_pulse_stretch: LEN must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)            cnt_q <= '0;
      else if (trig)          cnt_q <= CW'(LEN);
      else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
   end

   assign pulse = (cnt_q != '0);

   a_r3_r9_pulse_starts: assert property (@(posedge clk) disable iff (!arst_n)
      trig |=> pulse);

   a_r3_pulse_ends: assert property (@(posedge clk) disable iff (!arst_n)
      (!pulse && !trig) |=> !pulse);
endmodule

// File: rtl/pm_wake_latch.sv
module pm_wake_latch #(
   parameter int WAKE_W   = 3,
   parameter bit SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              in_d3c,
   input  logic              in_g3,
   input  logic              aux_det,
   input  logic              pwr_good,
   input  logic              pme_en,
   input  logic [WAKE_W-1:0] wake_evt,
   input  logic              pme_clr,
   output logic              pme_n
);
   logic pend_q;
   logic pend_d;
   logic set_ev;
   logic lost;
   logic clr_ev;

   assign set_ev = in_d3c && pme_en && aux_det && (|wake_evt);
   assign lost   = (!pwr_good && !aux_det) || in_g3;
   assign clr_ev = pme_clr || lost;

   if (SET_WINS) begin : g_set_first
      assign pend_d = set_ev || (pend_q && !clr_ev);
   end else begin : g_clr_first
      assign pend_d = (set_ev || pend_q) && !clr_ev;
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) pend_q <= 1'b0;
      else         pend_q <= pend_d;
   end

   assign pme_n = !pend_q;

   a_r10_sets: assert property (@(posedge clk) disable iff (!arst_n)
      (set_ev && (SET_WINS || !clr_ev)) |=> !pme_n);

   a_r10_no_spurious: assert property (@(posedge clk) disable iff (!arst_n)
      (pme_n && !set_ev) |=> pme_n);

   a_r11_holds: assert property (@(posedge clk) disable iff (!arst_n)
      (!pme_n && !pme_clr && !lost) |=> !pme_n);
endmodule

// File: rtl/pci_pm_tracker.sv
module pci_pm_tracker
   import pm_track_pkg::*;
#(
   parameter int WAKE_W       = 3,
   parameter int PULSE_LEN    = 2,
   parameter bit PME_SET_WINS = 1'b1
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              pci_rst_n,
   input  logic [1:0]        pm_field,
   input  logic              aux_det,
   input  logic              pwr_good,
   input  logic              pme_en,
   input  logic [WAKE_W-1:0] wake_evt,
   input  logic              sw_enable,
   input  logic              pme_clr,
   output logic [ST_N-1:0]   pm_state,
   output logic              clk_gate_req,
   output logic              bus_isolate,
   output logic              mac_block,
   output logic              pme_n,
   output logic              rst_por,
   output logic              rst_keep_pme,
   output logic              phy_rst_req
);
   if (WAKE_W < 1 || WAKE_W > 8) begin : g_bad_wake
      $error("pci_pm_tracker: WAKE_W must be 1..8");
   end

   pm_state_e        state_q;
   logic [RQ_N-1:0]  rq_trig;
   logic [RQ_N-1:0]  rq_pulse;
   logic             in_d3c;

   pm_state_fsm u_fsm (
      .clk       (clk),
      .arst_n    (arst_n),
      .pci_rst_n (pci_rst_n),
      .pm_field  (pm_field),
      .aux_det   (aux_det),
      .pwr_good  (pwr_good),
      .sw_enable (sw_enable),
      .state_q   (state_q),
      .ev_por    (rq_trig[RQ_POR]),
      .ev_keep   (rq_trig[RQ_KEEP]),
      .ev_phy    (rq_trig[RQ_PHY])
   );

   for (genvar i = 0; i < RQ_N; i++) begin : g_rq
      pm_pulse_stretch #(.LEN(PULSE_LEN)) u_pulse (
         .clk    (clk),
         .arst_n (arst_n),
         .trig   (rq_trig[i]),
         .pulse  (rq_pulse[i])
      );
   end

   assign in_d3c = (state_q == PS_D3C);

   pm_wake_latch #(.WAKE_W(WAKE_W), .SET_WINS(PME_SET_WINS)) u_wake (
      .clk      (clk),
      .arst_n   (arst_n),
      .in_d3c   (in_d3c),
      .in_g3    (state_q == PS_G3),
      .aux_det  (aux_det),
      .pwr_good (pwr_good),
      .pme_en   (pme_en),
      .wake_evt (wake_evt),
      .pme_clr  (pme_clr),
      .pme_n    (pme_n)
   );

   assign pm_state     = state_q;
   assign clk_gate_req = in_d3c;
   assign bus_isolate  = in_d3c;
   assign mac_block    = in_d3c;
   assign rst_por      = rq_pulse[RQ_POR];
   assign rst_keep_pme = rq_pulse[RQ_KEEP];
   assign phy_rst_req  = rq_pulse[RQ_PHY];

   a_r9_wake_from_cold: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PS_D3C && pwr_good) |=> (rst_keep_pme && phy_rst_req && !rst_por));

   a_r3_leave_g3: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == PS_G3 && (pwr_good || aux_det)) |=> rst_por);
endmodule

// File: tb/tb_pci_pm_tracker.sv
`timescale 1ns/100ps
module tb_pci_pm_tracker;
   localparam logic [4:0] S_G3 = 5'b00001, S_D0U = 5'b00010, S_D0A = 5'b00100,
                          S_D3H = 5'b01000, S_D3C = 5'b10000;

   logic clk = 1'b0;
   logic arst_n = 1'b0;
   logic pci_rst_n = 1'b1;
   logic [1:0] pm_field = 2'b00;
   logic aux_det = 1'b0, pwr_good = 1'b0, pme_en = 1'b0;
   logic [2:0] wake_evt = 3'b000;
   logic sw_enable = 1'b0, pme_clr = 1'b0;
   logic [4:0] pm_state;
   logic clk_gate_req, bus_isolate, mac_block, pme_n, rst_por, rst_keep_pme, phy_rst_req;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   pci_pm_tracker dut (
      .clk(clk), .arst_n(arst_n), .pci_rst_n(pci_rst_n), .pm_field(pm_field),
      .aux_det(aux_det), .pwr_good(pwr_good), .pme_en(pme_en), .wake_evt(wake_evt),
      .sw_enable(sw_enable), .pme_clr(pme_clr), .pm_state(pm_state),
      .clk_gate_req(clk_gate_req), .bus_isolate(bus_isolate), .mac_block(mac_block),
      .pme_n(pme_n), .rst_por(rst_por), .rst_keep_pme(rst_keep_pme), .phy_rst_req(phy_rst_req)
   );

   // {pci_rst_n, pm_field[1:0], aux_det, pwr_good, sw_enable, expected state[4:0]}
   localparam logic [10:0] VEC [0:16] = '{
      {1'b1, 2'b00, 1'b0, 1'b1, 1'b0, S_D0U},  // R3 G3 -> D0U
      {1'b0, 2'b00, 1'b0, 1'b1, 1'b1, S_D0U},  // R4 bus reset holds
      {1'b1, 2'b00, 1'b0, 1'b1, 1'b1, S_D0A},  // R4
      {1'b1, 2'b11, 1'b0, 1'b1, 1'b0, S_D3H},  // R5
      {1'b1, 2'b11, 1'b0, 1'b1, 1'b0, S_D3H},  // R6 no fall
      {1'b0, 2'b11, 1'b0, 1'b1, 1'b0, S_D0U},  // R6 fall
      {1'b1, 2'b00, 1'b0, 1'b1, 1'b1, S_D0A},  // R4
      {1'b1, 2'b11, 1'b0, 1'b1, 1'b0, S_D3H},  // R5
      {1'b1, 2'b11, 1'b1, 1'b0, 1'b0, S_D3C},  // R7
      {1'b0, 2'b00, 1'b1, 1'b0, 1'b0, S_D3C},  // R8 reset ignored
      {1'b1, 2'b11, 1'b1, 1'b0, 1'b0, S_D3C},  // R8 field ignored
      {1'b1, 2'b00, 1'b1, 1'b1, 1'b0, S_D0U},  // R9
      {1'b1, 2'b00, 1'b1, 1'b1, 1'b1, S_D0A},  // R4
      {1'b0, 2'b11, 1'b1, 1'b1, 1'b0, S_D0U},  // R5 reset beats field
      {1'b1, 2'b00, 1'b0, 1'b0, 1'b0, S_G3 },  // R2
      {1'b1, 2'b00, 1'b1, 1'b0, 1'b0, S_D3C},  // R3 via aux
      {1'b1, 2'b00, 1'b0, 1'b0, 1'b0, S_G3 }   // R2
   };

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      arst_n = 1'b0; pci_rst_n = 1'b1; pm_field = 2'b00; aux_det = 1'b0; pwr_good = 1'b0;
      pme_en = 1'b0; wake_evt = 3'b000; sw_enable = 1'b0; pme_clr = 1'b0;
      step(); step();
      arst_n = 1'b1;
      step();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         bad++;
         $display("FAIL watchdog act=%0d exp=done", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      do_reset();
      check(pm_state == S_G3, "R1 reset state", pm_state, S_G3);
      check({pme_n, rst_por, rst_keep_pme, phy_rst_req, clk_gate_req} == 5'b10000,
            "R1 reset outputs", {pme_n, rst_por, rst_keep_pme, phy_rst_req, clk_gate_req}, 5'b10000);

      // vector walk
      for (int i = 0; i < 17; i++) begin
         {pci_rst_n, pm_field, aux_det, pwr_good, sw_enable} = VEC[i][10:5];
         step();
         check(pm_state == VEC[i][4:0], $sformatf("R2-walk row %0d state", i), pm_state, VEC[i][4:0]);
         check(bus_isolate == (VEC[i][4:0] == S_D3C) && clk_gate_req == bus_isolate && mac_block == bus_isolate,
               $sformatf("R8 row %0d flags", i), {clk_gate_req, bus_isolate, mac_block}, {3{VEC[i][4:0] == S_D3C}});
      end

      // R3 power-on pulse width
      do_reset();
      pwr_good = 1'b1;
      step();
      check(pm_state == S_D0U && rst_por && phy_rst_req && !rst_keep_pme, "R3 por start",
            {pm_state, rst_por, rst_keep_pme, phy_rst_req}, {S_D0U, 3'b101});
      step();
      check(rst_por, "R3 por second cycle", rst_por, 1);
      step();
      check(!rst_por && !phy_rst_req, "R3 por ended", {rst_por, phy_rst_req}, 0);

      // R6 held-low reset does not wake from D3 hot
      sw_enable = 1'b1; step();
      sw_enable = 1'b0; pm_field = 2'b11; step();
      check(pm_state == S_D3H, "R5 enter D3H", pm_state, S_D3H);
      pm_field = 2'b00; pci_rst_n = 1'b0; step();
      check(pm_state == S_D3H, "R6 fall with wrong field", pm_state, S_D3H);
      pm_field = 2'b11; step();
      check(pm_state == S_D3H, "R6 held low no fall", pm_state, S_D3H);
      pci_rst_n = 1'b1; step();
      pci_rst_n = 1'b0; step();
      check(pm_state == S_D0U && rst_keep_pme && !phy_rst_req && !rst_por, "R6 D3H to D0U scope",
            {pm_state, rst_por, rst_keep_pme, phy_rst_req}, {S_D0U, 3'b010});

      // R10 / R11 wake latch
      do_reset();
      aux_det = 1'b1; step();
      check(pm_state == S_D3C && rst_por, "R3 G3 to D3C", {pm_state, rst_por}, {S_D3C, 1'b1});
      wake_evt = 3'b001; step();
      check(pme_n, "R10 pme_en low ignored", pme_n, 1);
      pme_en = 1'b1; wake_evt = 3'b100; step();
      check(!pme_n, "R10 link change sets", pme_n, 0);
      wake_evt = 3'b000; step();
      check(!pme_n, "R11 held", pme_n, 0);
      pwr_good = 1'b1; step();
      check(pm_state == S_D0U && rst_keep_pme && phy_rst_req && !rst_por, "R9 D3C to D0U scope",
            {pm_state, rst_por, rst_keep_pme, phy_rst_req}, {S_D0U, 3'b011});
      check(!pme_n, "R11 survives wake reset", pme_n, 0);
      pme_clr = 1'b1; step();
      pme_clr = 1'b0;
      check(pme_n, "R11 cleared", pme_n, 1);
      wake_evt = 3'b001; step();
      check(pme_n, "R10 not in D0U", pme_n, 1);
      wake_evt = 3'b000; pwr_good = 1'b0; step();
      check(pm_state == S_D3C, "R7 D0U to D3C", pm_state, S_D3C);
      wake_evt = 3'b010; pme_clr = 1'b1; step();
      pme_clr = 1'b0; wake_evt = 3'b000;
      check(!pme_n, "R11 set beats clear", pme_n, 0);
      aux_det = 1'b0; step();
      check(pm_state == S_G3, "R2 power lost", pm_state, S_G3);
      check(pme_n, "R11 lost in G3", pme_n, 1);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule